// File: doc/BRIEF.md
# DRAM Bank Precharge State Tracker

This block follows the open or idle condition of every bank in a DDR2-style memory device and enforces the recovery timing that follows a precharge. It sits beside a memory controller's command scheduler. It watches the decoded command stream, one command per clock, and publishes two flags per bank: one for whether the bank may take column accesses, and one for whether it may be activated. It also raises an error pulse whenever a command breaks a bank rule.

Precharge has two scopes. With A10 low, only the addressed bank closes, and that bank waits tRP cycles before it may be activated again. With A10 high, every bank closes whatever its previous state was, the bank address is not used, and every bank waits tRPA cycles. A READ or WRITE that carries the auto-precharge flag closes its bank in the command cycle and starts the tRP wait. Both waits are counted in clock cycles and are set by parameters.

Top module: `bank_state_tracker`

## Requirements
- R1: After reset every bank is idle (`bank_open_o` = 0), every bank may be activated (`act_ok_o` all ones), and `err_o` is 0.
- R2: Command code 1 (ACTIVATE) to a bank whose `act_ok_o` bit is high opens that bank in the next cycle. The bank's `bank_open_o` bit rises, its `act_ok_o` bit falls, and `err_o` stays low.
- R3: ACTIVATE to a bank that is open, or that is still inside its precharge wait, gives `err_o` high for one cycle and changes no bank state.
- R4: Command code 2 (READ) or 3 (WRITE) to an idle bank gives `err_o` high for one cycle and changes no bank state. The auto-precharge flag has no effect in this case.
- R5: READ or WRITE to an open bank with `auto_pre_i` low is legal and leaves the bank open.
- R6: READ or WRITE to an open bank with `auto_pre_i` high closes the bank in the next cycle. An ACTIVATE to that bank issued k cycles after the command is legal exactly when k >= T_RP.
- R7: Command code 4 (PRECHARGE) with `a10_i` low closes only the bank on `bank_i` and leaves every other bank unchanged. An ACTIVATE to that bank issued k cycles later is legal exactly when k >= T_RP.
- R8: PRECHARGE with `a10_i` high closes all banks whatever `bank_i` holds. An ACTIVATE to any bank issued k cycles later is legal exactly when k >= T_RPA.
- R9: The all-bank wait of R8 also applies to banks that were already idle.
- R10: A single-bank PRECHARGE to an idle bank is legal (no error), and it restarts that bank's wait from the new command.
- R11: Command code 0 (NOP), and the unused codes 5 to 7, change no bank state and never raise `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Command code: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE |
| bank_i | input | 3 | Bank address of the command |
| a10_i | input | 1 | Precharge scope: 1 = all banks, 0 = addressed bank |
| auto_pre_i | input | 1 | Auto-precharge request on READ/WRITE |
| bank_open_o | output | 8 | Per-bank open flag; a READ or WRITE is legal where it is set |
| act_ok_o | output | 8 | Per-bank flag: ACTIVATE legal this cycle |
| err_o | output | 1 | One-cycle pulse in the cycle after an illegal command |

## Verification
The assertions assume that `cmd_i`, `bank_i`, `a10_i` and `auto_pre_i` are settled before each rising edge and carry at most one command per cycle. They also assume that the bank address always names one of the configured banks. The bench drives every input on the falling edge and sets the command back to NOP right after each sampling edge, so each command is seen at exactly one edge. It uses only bank addresses 0 to 7, which are all valid with the default of eight banks.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;
endpackage

// File: rtl/bank_trk_decode.sv
module bank_trk_decode #(
  parameter int NUM_BANKS = 8,
  parameter int BA_W      = 3
) (
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 a10_i,
  input  logic                 auto_pre_i,
  input  logic [NUM_BANKS-1:0] open_i,
  input  logic [NUM_BANKS-1:0] act_ok_i,
  output logic [NUM_BANKS-1:0] act_o,
  output logic [NUM_BANKS-1:0] pre_o,
  output logic                 pre_all_o,
  output logic                 err_o
);
  import bank_trk_pkg::*;

  logic [NUM_BANKS-1:0] sel;

  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) sel[i] = (int'(bank_i) == i);
  end

  always_comb begin
    act_o     = '0;
    pre_o     = '0;
    pre_all_o = 1'b0;
    err_o     = 1'b0;
    case (cmd_i)
      CMD_ACT: begin
        if ((act_ok_i & sel) != '0) act_o = sel;
        else                        err_o = 1'b1;
      end
      CMD_RD, CMD_WR: begin
        if ((open_i & sel) == '0) err_o = 1'b1;
        else if (auto_pre_i)      pre_o = sel;
      end
      CMD_PRE: begin
        if (a10_i) pre_all_o = 1'b1;
        else       pre_o     = sel;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bank_trk_slot.sv
module bank_trk_slot #(
  parameter int CNT_W = 3,
  parameter int T_RP  = 4,
  parameter int T_RPA = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic pre_i,
  input  logic pre_all_i,
  output logic open_o,
  output logic act_ok_o
);
  // load value is one less: the command edge itself counts as the first cycle
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RPA = CNT_W'(T_RPA - 1);

  logic             open_q;
  logic [CNT_W-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      wait_q <= '0;
    end else begin
      if (pre_all_i) begin
        open_q <= 1'b0;
        wait_q <= LD_RPA;
      end else if (pre_i) begin
        open_q <= 1'b0;
        wait_q <= LD_RP;
      end else begin
        if (act_i) open_q <= 1'b1;
        if (wait_q != '0) wait_q <= wait_q - 1'b1;
      end
    end
  end

  assign open_o   = open_q;
  assign act_ok_o = !open_q && (wait_q == '0);
endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker #(
  parameter int NUM_BANKS = 8,
  parameter int T_RP      = 4,
  parameter int T_RPA     = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic                         a10_i,
  input  logic                         auto_pre_i,
  output logic [NUM_BANKS-1:0]         bank_open_o,
  output logic [NUM_BANKS-1:0]         act_ok_o,
  output logic                         err_o
);
  localparam int BA_W  = $clog2(NUM_BANKS);
  localparam int MAX_T = (T_RP > T_RPA) ? T_RP : T_RPA;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [NUM_BANKS-1:0] act_s, pre_s;
  logic                 pre_all_s, err_s, err_q;

  bank_trk_decode #(
    .NUM_BANKS(NUM_BANKS),
    .BA_W     (BA_W)
  ) u_decode (
    .cmd_i     (cmd_i),
    .bank_i    (bank_i),
    .a10_i     (a10_i),
    .auto_pre_i(auto_pre_i),
    .open_i    (bank_open_o),
    .act_ok_i  (act_ok_o),
    .act_o     (act_s),
    .pre_o     (pre_s),
    .pre_all_o (pre_all_s),
    .err_o     (err_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_trk_slot #(
      .CNT_W(CNT_W),
      .T_RP (T_RP),
      .T_RPA(T_RPA)
    ) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act_s[b]),
      .pre_i    (pre_s[b]),
      .pre_all_i(pre_all_s),
      .open_o   (bank_open_o[b]),
      .act_ok_o (act_ok_o[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_s;
  end

  assign err_o = err_q;
endmodule

// File: rtl/bank_trk_chk.sv
module bank_trk_chk #(
  parameter int NUM_BANKS = 8,
  parameter int T_RP      = 4,
  parameter int T_RPA     = 5
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [2:0]                   cmd_i,
  input logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input logic                         a10_i,
  input logic                         auto_pre_i,
  input logic [NUM_BANKS-1:0]         bank_open_o,
  input logic [NUM_BANKS-1:0]         act_ok_o,
  input logic                         err_o
);
  localparam int BA_W = $clog2(NUM_BANKS);

  logic                 v_q, a10_q, ap_q;
  logic [2:0]           cmd_q;
  logic [BA_W-1:0]      bank_q;
  logic [NUM_BANKS-1:0] open_q, ok_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0; a10_q <= 1'b0; ap_q <= 1'b0; cmd_q <= '0;
      bank_q <= '0; open_q <= '0; ok_q <= '0;
    end else begin
      v_q <= 1'b1; a10_q <= a10_i; ap_q <= auto_pre_i; cmd_q <= cmd_i;
      bank_q <= bank_i; open_q <= bank_open_o; ok_q <= act_ok_o;
    end
  end

  always_comb mask_q = NUM_BANKS'(1) << bank_q;

  assert_act_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && cmd_q == 3'd1 && ok_q[bank_q]) |-> (bank_open_o[bank_q] && !err_o));

  assert_bad_act_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && cmd_q == 3'd1 && !ok_q[bank_q]) |-> (err_o && bank_open_o == open_q));

  assert_rw_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && (cmd_q == 3'd2 || cmd_q == 3'd3) && !open_q[bank_q])
      |-> (err_o && bank_open_o == open_q));

  assert_autopre_close_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && (cmd_q == 3'd2 || cmd_q == 3'd3) && open_q[bank_q] && ap_q)
      |-> (!bank_open_o[bank_q] && !err_o && (T_RP < 2 || !act_ok_o[bank_q])));

  assert_pre_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && cmd_q == 3'd4 && !a10_q)
      |-> (((bank_open_o ^ open_q) & ~mask_q) == '0 && !bank_open_o[bank_q] && !err_o));

  assert_pre_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && cmd_q == 3'd4 && a10_q)
      |-> (bank_open_o == '0 && !err_o && (T_RPA < 2 || act_ok_o == '0)));

  assert_nop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && cmd_q != 3'd1 && cmd_q != 3'd2 && cmd_q != 3'd3 && cmd_q != 3'd4)
      |-> (!err_o && bank_open_o == open_q));
endmodule

bind bank_state_tracker bank_trk_chk #(
  .NUM_BANKS(NUM_BANKS),
  .T_RP     (T_RP),
  .T_RPA    (T_RPA)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_i      (cmd_i),
  .bank_i     (bank_i),
  .a10_i      (a10_i),
  .auto_pre_i (auto_pre_i),
  .bank_open_o(bank_open_o),
  .act_ok_o   (act_ok_o),
  .err_o      (err_o)
);

// File: tb/bank_state_tracker_bench.sv
module bank_state_tracker_bench;
  localparam int NB   = 8;
  localparam int TRP  = 4;
  localparam int TRPA = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd = 3'd0;
  logic [2:0]    bank = 3'd0;
  logic          a10 = 1'b0;
  logic          ap = 1'b0;
  logic [NB-1:0] open_v, ok_v;
  logic          err;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  bank_state_tracker #(.NUM_BANKS(NB), .T_RP(TRP), .T_RPA(TRPA)) u_bank_state_tracker (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bank_i(bank), .a10_i(a10),
    .auto_pre_i(ap), .bank_open_o(open_v), .act_ok_o(ok_v), .err_o(err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the rising edge
  task automatic issue(logic [2:0] c, logic [2:0] b, logic a, logic p);
    @(negedge clk);
    cmd = c; bank = b; a10 = a; ap = p;
    @(posedge clk); #1;
    cmd = 3'd0; a10 = 1'b0; ap = 1'b0;
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) issue(3'd0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 open", 32'(open_v), 32'h0);
    chk("R1 act_ok", 32'(ok_v), 32'hFF);
    chk("R1 err", 32'(err), 32'h0);
  endtask

  task automatic t_activate();
    issue(3'd1, 3'd2, 1'b0, 1'b0);
    chk("R2 open", 32'(open_v), 32'h04);
    chk("R2 act_ok", 32'(ok_v[2]), 32'h0);
    chk("R2 err", 32'(err), 32'h0);
    issue(3'd2, 3'd2, 1'b0, 1'b0);
    chk("R5 read keeps open", 32'(open_v), 32'h04);
    chk("R5 read err", 32'(err), 32'h0);
    issue(3'd3, 3'd2, 1'b0, 1'b0);
    chk("R5 write keeps open", 32'(open_v), 32'h04);
    chk("R5 write err", 32'(err), 32'h0);
  endtask

  task automatic t_bad_act();
    issue(3'd1, 3'd2, 1'b0, 1'b0);
    chk("R3 act on open err", 32'(err), 32'h1);
    chk("R3 act on open state", 32'(open_v), 32'h04);
    issue(3'd0, 3'd0, 1'b0, 1'b0);
    chk("R3 err is one pulse", 32'(err), 32'h0);
  endtask

  task automatic t_rw_idle();
    issue(3'd2, 3'd5, 1'b0, 1'b1);
    chk("R4 read idle err", 32'(err), 32'h1);
    chk("R4 read idle state", 32'(open_v), 32'h04);
    chk("R4 read idle act_ok", 32'(ok_v[5]), 32'h1);
    issue(3'd3, 3'd7, 1'b0, 1'b0);
    chk("R4 write idle err", 32'(err), 32'h1);
    chk("R4 write idle state", 32'(open_v), 32'h04);
  endtask

  task automatic t_autopre();
    issue(3'd3, 3'd2, 1'b0, 1'b1);
    chk("R6 closes", 32'(open_v), 32'h0);
    chk("R6 err", 32'(err), 32'h0);
    chk("R6 wait", 32'(ok_v[2]), 32'h0);
    nops(TRP - 2);
    issue(3'd1, 3'd2, 1'b0, 1'b0);
    chk("R6 early act err", 32'(err), 32'h1);
    chk("R6 early act state", 32'(open_v), 32'h0);
    issue(3'd1, 3'd2, 1'b0, 1'b0);
    chk("R6 act at tRP", 32'(open_v), 32'h04);
    chk("R6 act at tRP err", 32'(err), 32'h0);
  endtask

  task automatic t_pre_single();
    issue(3'd1, 3'd6, 1'b0, 1'b0);
    issue(3'd4, 3'd2, 1'b0, 1'b0);
    chk("R7 closes named only", 32'(open_v), 32'h40);
    chk("R7 err", 32'(err), 32'h0);
    nops(TRP - 1);
    chk("R7 act_ok after tRP", 32'(ok_v[2]), 32'h1);
    issue(3'd4, 3'd3, 1'b0, 1'b0);
    chk("R10 idle pre legal", 32'(err), 32'h0);
    chk("R10 idle pre starts wait", 32'(ok_v[3]), 32'h0);
    nops(1);
    issue(3'd4, 3'd3, 1'b0, 1'b0);
    nops(TRP - 2);
    issue(3'd1, 3'd3, 1'b0, 1'b0);
    chk("R10 restarted wait err", 32'(err), 32'h1);
    issue(3'd1, 3'd3, 1'b0, 1'b0);
    chk("R10 act after restart", 32'(open_v), 32'h48);
    chk("R7 other bank kept", 32'(open_v[6]), 32'h1);
  endtask

  task automatic t_pre_all();
    // open: 3, 6; bank 2 idle
    issue(3'd4, 3'd2, 1'b1, 1'b0);
    chk("R8 all closed", 32'(open_v), 32'h0);
    chk("R8 all waiting", 32'(ok_v), 32'h0);
    chk("R8 err", 32'(err), 32'h0);
    nops(TRPA - 2);
    issue(3'd1, 3'd2, 1'b0, 1'b0);
    chk("R9 idle bank waits tRPA", 32'(err), 32'h1);
    chk("R8 act_ok at tRPA", 32'(ok_v), 32'hFF);
    issue(3'd1, 3'd2, 1'b0, 1'b0);
    chk("R9 act after tRPA", 32'(open_v), 32'h04);
    chk("R9 act err", 32'(err), 32'h0);
  endtask

  task automatic t_nop();
    for (int c = 5; c < 8; c++) begin
      issue(3'(c), 3'd2, 1'b1, 1'b1);
      chk("R11 unused code state", 32'(open_v), 32'h04);
      chk("R11 unused code err", 32'(err), 32'h0);
    end
    issue(3'd0, 3'd2, 1'b1, 1'b1);
    chk("R11 nop state", 32'(open_v), 32'h04);
    chk("R11 nop err", 32'(err), 32'h0);
  endtask

  initial begin
    t_reset();
    t_activate();
    t_bad_act();
    t_rw_idle();
    t_autopre();
    t_pre_single();
    t_pre_all();
    t_nop();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule